// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

This block turns a 32-bit linear address into a physical address. The mapping lives in memory as a single page directory and a set of page tables. The top ten bits of the linear address pick a directory word. That word holds the frame of a page table. The next ten bits pick a word in that table, and that word holds the frame of a 4 KiB physical page. The low twelve bits pass through unchanged as the byte offset. A directory entry therefore spans 4 MiB of linear space, and a table entry spans 4 KiB. Bit 0 of either entry is its present flag.

A 32-entry fully associative cache of recent translations sits in front of the walker. On a hit the block answers without touching memory. On a miss it fetches the directory entry, then the table entry, through a single memory read port. It then stores the translation in the cache and answers. A software-visible directory base register sets where the directory lives, and writing that register empties the cache.

The requester side accepts one request at a time. A request is taken when `req_valid` and `req_ready` are both high, and the answer comes back as a one-cycle pulse on `rsp_valid`. The memory side issues a read address that is held until the memory accepts it. The read data returns later as a one-cycle pulse.

Top module: `page_xlate`

## Requirements
- R1: A request whose page is cached raises `rsp_valid` on the clock edge after the edge that accepted it. It returns `{cached frame, linear[11:0]}` with `rsp_fault` low and performs no memory read.
- R2: A request whose page is not cached performs exactly two reads. The first is at `base + linear[31:22]*4` and the second at `{directory word[31:12], linear[21:12], 2'b00}`. The answer is `{table word[31:12], linear[11:0]}`.
- R3: If the directory word has bit 0 clear, only that one read is made. The answer has `rsp_fault` high and `rsp_paddr` zero, and nothing is cached, so a repeat of the same request reads the directory again.
- R4: If the table word has bit 0 clear after both reads, the answer has `rsp_fault` high and `rsp_paddr` zero. Nothing is cached, so a repeat makes both reads again.
- R5: Up to 32 distinct successful translations are held at once, and at most one cached entry ever matches a given page.
- R6: Successful walks fill the cache in round-robin order over its 32 slots, replacing the oldest fill. The fill pointer advances by one per fill and is not moved by invalidation.
- R7: Writing the base register stores `wdata[31:12]` with the low twelve bits forced to zero. It also invalidates every cached entry on that edge, so the next request for any page walks from the new base.
- R8: If the base register is written while a request is in flight, that request completes with the walk it already began, from the old base. Its result is not cached.
- R9: `req_ready` is low from the accepting edge until the response, and each accepted request yields exactly one single-cycle `rsp_valid` pulse.
- R10: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until `mem_req_ready` is seen high. A read is requested only while a request is in flight.
- R11: After reset `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and no entry is cached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New directory base; low 12 bits ignored |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_fault | output | 1 | Translation failed on a non-present entry |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| mem_req_valid | output | 1 | Memory read requested |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | One-cycle pulse with read data |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The assertions assume that memory returns exactly one data pulse per accepted read, and only after accepting it. They also assume that the requester keeps `base_we` low while reset is released. The bench memory model schedules each reply one to three cycles after the handshake and never keeps more than one reply pending. It toggles `mem_req_ready` at random, which exercises the hold rule. Directory and table words come from a hash of the address, so roughly one entry in 32 is non-present. Directed searches over that hash pick pages that fault at either level, and a bench-side copy of the cache contents and fill pointer predicts which random requests must hit.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int ENTRIES  = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int OFF_BITS = 32 - DIR_BITS - TBL_BITS;
  localparam int VPN_W    = DIR_BITS + TBL_BITS;
  localparam int PFN_W    = 32 - OFF_BITS;
  localparam int PTR_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_DIR_REQ, S_DIR_WAIT, S_PTE_REQ, S_PTE_WAIT
  } st_t;

  st_t                st;
  logic [31:0]        la_q;
  logic [31:0]        base_q;
  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PFN_W-1:0]   pfn [ENTRIES];
  logic [PTR_W-1:0]   rr;
  logic               stale;
  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0]   hit_pfn;

  wire [VPN_W-1:0]    la_vpn = la_q[31:OFF_BITS];
  wire [DIR_BITS-1:0] la_dir = la_q[31 -: DIR_BITS];
  wire [TBL_BITS-1:0] la_tbl = la_q[OFF_BITS +: TBL_BITS];
  wire                hit    = |hit_vec;
  wire                pres   = mem_rsp_data[0];
  wire                fill   = (st == S_PTE_WAIT) && mem_rsp_valid && pres && !stale && !base_we;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DIR_REQ) || (st == S_PTE_REQ);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag[i] == la_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_pfn = hit_pfn | pfn[i];
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag[rr] <= la_vpn;
      pfn[rr] <= mem_rsp_data[31:OFF_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      la_q         <= '0;
      base_q       <= '0;
      vld          <= '0;
      rr           <= '0;
      stale        <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_paddr    <= '0;
      mem_req_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          la_q  <= req_addr;
          stale <= 1'b0;
          st    <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_paddr <= {hit_pfn, la_q[OFF_BITS-1:0]};
          st        <= S_IDLE;
        end else begin
          mem_req_addr <= base_q + 32'({la_dir, 2'b00});
          st           <= S_DIR_REQ;
        end
        S_DIR_REQ: if (mem_req_ready) st <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          if (!pres) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '0;
            st        <= S_IDLE;
          end else begin
            mem_req_addr <= {mem_rsp_data[31:OFF_BITS], la_tbl, 2'b00};
            st           <= S_PTE_REQ;
          end
        end
        S_PTE_REQ: if (mem_req_ready) st <= S_PTE_WAIT;
        S_PTE_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= !pres;
          rsp_paddr <= pres ? {mem_rsp_data[31:OFF_BITS], la_q[OFF_BITS-1:0]} : '0;
          st        <= S_IDLE;
          if (fill) begin
            vld[rr] <= 1'b1;
            rr      <= (rr == PTR_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (base_we) begin
        base_q <= {base_wdata[31:OFF_BITS], {OFF_BITS{1'b0}}};
        vld    <= '0;
        if (st != S_IDLE) stale <= 1'b1;
      end
    end
  end

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R5
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (vld == '0));

  // R3
  fault_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(base_we)) |-> $stable(vld));

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate u_page_xlate (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int checks = 0, errors = 0;
  int nreads = 0;
  int rsp_cnt = 0;
  logic [31:0] rsp_word;
  logic [31:0] rd_addr [2];
  logic [31:0] base = '0;
  bit          mvld [NENT];
  logic [19:0] mvpn [NENT];
  int          mptr = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return {h[31:1], h[6:2] != 5'd0};
  endfunction

  function automatic void walk(input logic [31:0] b, input logic [31:0] la, output int n,
                               output bit f, output logic [31:0] pa, output logic [31:0] a0,
                               output logic [31:0] a1);
    logic [31:0] pde, pte;
    a0 = b + {20'd0, la[31:22], 2'b00};
    pde = mem_word(a0);
    a1 = '0; pa = '0;
    if (!pde[0]) begin n = 1; f = 1'b1; return; end
    a1 = {pde[31:12], la[21:12], 2'b00};
    pte = mem_word(a1);
    n = 2;
    if (!pte[0]) begin f = 1'b1; return; end
    f = 1'b0;
    pa = {pte[31:12], la[11:0]};
  endfunction

  function automatic logic [31:0] find_la(input logic [31:0] start, input logic [31:0] step, input int kind);
    int n; bit f; logic [31:0] pa, a0, a1, la;
    for (int k = 0; k < 4096; k++) begin
      la = start + k * step;
      walk(base, la, n, f, pa, a0, a1);
      if ((kind == 0 && !f) || (kind == 1 && n == 1) || (kind == 2 && n == 2 && f)) return la;
    end
    return start;
  endfunction

  function automatic int mfind(input logic [19:0] vpn);
    for (int i = 0; i < NENT; i++) if (mvld[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void mflush();
    for (int i = 0; i < NENT; i++) mvld[i] = 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rsp_word; end
      end
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        if (nreads < 2) rd_addr[nreads] = mem_req_addr;
        nreads++;
        rsp_word = mem_word(mem_req_addr);
        rsp_cnt = 1 + ($urandom % 3);
      end
    end
  end

  task automatic set_base(input logic [31:0] nb);
    @(negedge clk); base_we = 1'b1; base_wdata = nb;
    @(negedge clk); base_we = 1'b0;
    base = {nb[31:12], 12'h000};
    mflush();
  endtask

  task automatic run(input logic [31:0] la, input bit mid, input logic [31:0] nb, input string tag);
    int idx, n, lat; bit f; logic [31:0] pa, a0, a1;
    idx = mfind(la[31:12]);
    walk(base, la, n, f, pa, a0, a1);
    if (idx >= 0) n = 0;
    @(negedge clk); req_valid = 1'b1; req_addr = la; nreads = 0;
    @(negedge clk); req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 32'd0);
    if (mid) begin base_we = 1'b1; base_wdata = nb; end
    lat = 0;
    do begin @(negedge clk); base_we = 1'b0; lat++; end while (!rsp_valid && lat < 300);
    chk(rsp_valid, tag, "response seen", 32'(rsp_valid), 32'd1);
    chk(rsp_fault == f, tag, "fault", 32'(rsp_fault), 32'(f));
    chk(rsp_paddr == pa, tag, "paddr", rsp_paddr, pa);
    chk(nreads == n, tag, "memory reads", 32'(nreads), 32'(n));
    if (idx >= 0) chk(lat == 1, tag, "hit latency", 32'(lat), 32'd1);
    if (idx < 0 && nreads >= 1) chk(rd_addr[0] == a0, tag, "directory read addr", rd_addr[0], a0);
    if (idx < 0 && n == 2 && nreads >= 2) chk(rd_addr[1] == a1, tag, "table read addr", rd_addr[1], a1);
    if (idx < 0 && !f && !mid) begin
      mvld[mptr] = 1'b1; mvpn[mptr] = la[31:12];
      mptr = (mptr + 1) % NENT;
    end
    if (mid) begin base = {nb[31:12], 12'h000}; mflush(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] la_ok, la_pf, la_tf, la2;
    logic [31:0] pages [40];
    void'($urandom(32'd20240611));
    mflush();
    repeat (3) @(negedge clk);
    // R11
    chk(req_ready == 1'b1, "R11", "reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R11", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    set_base(32'h0010_0000);

    la_ok = find_la(32'h0000_0123, 32'h1000, 0);
    run(la_ok, 1'b0, '0, "R2");
    run(la_ok, 1'b0, '0, "R1");
    run(la_ok ^ 32'h0000_0F0F, 1'b0, '0, "R1");

    la_pf = find_la(32'h0040_0456, 32'h0040_0000, 1);
    run(la_pf, 1'b0, '0, "R3");
    run(la_pf, 1'b0, '0, "R3");
    la_tf = find_la(la_ok & 32'hFFC0_0000, 32'h1000, 2);
    run(la_tf, 1'b0, '0, "R4");
    run(la_tf, 1'b0, '0, "R4");

    // R5 and R6: fill 32 slots, all hit, then the 33rd evicts the oldest
    set_base(32'h0010_0000);
    la2 = 32'h0800_0000;
    for (int i = 0; i < 33; i++) begin
      la2 = find_la(la2 + 32'h1000, 32'h1000, 0);
      pages[i] = la2;
    end
    for (int i = 0; i < 32; i++) run(pages[i], 1'b0, '0, "R6");
    for (int i = 0; i < 32; i++) run(pages[i] + 32'h10, 1'b0, '0, "R5");
    run(pages[32], 1'b0, '0, "R6");
    run(pages[1], 1'b0, '0, "R6");
    run(pages[0], 1'b0, '0, "R6");

    // R7: low bits of the written base are dropped, and old entries are gone
    set_base(32'h0020_0ABC);
    run(pages[1], 1'b0, '0, "R7");
    run(pages[1], 1'b0, '0, "R7");

    // R8: base written mid-walk
    la2 = find_la(32'h1000_0000, 32'h1000, 0);
    run(la2, 1'b1, 32'h0030_0000, "R8");
    run(la2, 1'b0, '0, "R8");

    for (int i = 0; i < 40; i++) pages[i] = {$urandom} & 32'hFFFF_F000;
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 20) == 0) begin
        case ($urandom % 3)
          0: set_base(32'h0010_0000);
          1: set_base(32'h0020_0000);
          default: set_base(32'h003F_F000);
        endcase
      end
      run(pages[$urandom % 40] | ({$urandom} & 32'hFFF), 1'b0, '0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule